// File: doc/BRIEF.md
# Page-Mode NOR Read Controller

This block sits on the host side of an asynchronous parallel NOR memory that offers fast reads within a page. A host issues read requests with an address and a valid strobe. The block drives the memory's chip-enable, output-enable, write-enable and address pins. After a programmable number of clock cycles it samples the data bus and returns the value with a single-cycle response strobe. It accepts one request at a time, and only while it signals ready.

A page is eight words. The address bits from bit 3 of the memory's word address upward select the page. The block remembers which page is currently open and in which addressing mode it was opened. A request into that same page, in the same mode, waits only the short page wait. Any other access waits the full wait. The page is forgotten whenever chip-enable is released. That happens at reset, and after a run of idle ready cycles with no request. In byte mode the least significant request bit drives the byte-select line, and only the low data lane is returned.

Both waits are counted in clock cycles and are sampled when a request is accepted. The page wait is capped at the full wait.

Top module: `nor_page_reader`

## Requirements
- R1: While reset is held, and immediately after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `rsp_valid` is 0 and `req_ready` is 1. The first read after reset takes the full wait.
- R2: `mem_we_n` is 1 in every cycle.
- R3: A read that is not a page hit raises `rsp_valid` exactly `full_wait` clock edges after the accepting edge. From acceptance until the response, `mem_ce_n` and `mem_oe_n` are 0.
- R4: A read is a page hit when three conditions hold: a page is open, the bits of its memory word address from bit 3 upward equal those of the open page, and its mode equals the open page's mode. A page hit raises `rsp_valid` after the page wait instead of the full wait.
- R5: Once chip-enable has been released, the next read takes the full wait, even when it targets the previously open page. While `mem_ce_n` is 1, `mem_oe_n` is also 1.
- R6: After `IDLE_LIMIT` consecutive ready cycles with `req_valid` low, the block drives `mem_ce_n` and `mem_oe_n` to 1 and closes the page. A request in the cycle just before that limit is reached still sees the page open.
- R7: The two addressing modes map the request onto the memory pins as follows.
  - Byte mode (`byte_mode`=1): `mem_addr` = `req_addr[ADDR_W:1]` and `mem_bsel` = `req_addr[0]`. `rsp_data` carries `mem_dq[7:0]` with its upper bits zero.
  - Word mode: `mem_addr` = `req_addr[ADDR_W-1:0]`, `req_addr[ADDR_W]` is ignored, `mem_bsel` = 0, and `rsp_data` = `mem_dq`.
- R8: The wait applied to a page hit is the smaller of `page_wait` and `full_wait`.
- R9: A wait value of 0 behaves as 1.
- R10: The following hold for the request and response handshake.
  - `rsp_valid` is high for one cycle per accepted request.
  - `req_ready` is 0 from the accepting edge until the response, and 1 in the response cycle.
  - A request raised while `req_ready` is 0 is ignored: it leaves `mem_addr` and `mem_bsel` unchanged and produces no response.
- R11: A read in the open page, but in the other addressing mode, takes the full wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_mode | input | 1 | 1 selects byte addressing for the request being accepted |
| full_wait | input | WAIT_W | Cycles for a first or random access |
| page_wait | input | WAIT_W | Cycles for an access within the open page |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W+1 | Request address; word address in word mode, byte address in byte mode |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle strobe marking `rsp_data` valid |
| rsp_data | output | DATA_W | Returned read data |
| mem_addr | output | ADDR_W | Memory word address pins |
| mem_bsel | output | 1 | Memory byte-select line (used in byte mode) |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low (held high) |
| mem_dq | input | DATA_W | Memory data bus |

## Verification
The main function is exercised with several address sequences, each aimed at a different distinction:
- Runs that stay within one page, followed by a step to the next page, separate hits from misses.
- Repeated reads of the same page around the idle limit, at one cycle short of it and exactly at it, separate a page that is still open from one closed by the release of chip-enable.
- Byte-mode reads next to word-mode reads of the same page show that the mode is part of the hit decision, and that the byte-select line and low-lane return are correct.

The wait pairs (7,3), (2,5), (0,0) and (20,1) tell apart the plain page wait, the cap at the full wait, the zero clamp and long waits. The memory model returns a distinct value per address and byte, so a wrong pin address or lane shows up as wrong data.

// File: rtl/nor_rd_pkg.sv
// Shared definitions for the page-mode NOR read controller.
// Assumes: page size is a power of two words, given as its log2.
package nor_rd_pkg;
    localparam int PAGE_BITS_DEF = 3;   // eight words per page
    localparam int LANE_W        = 8;   // byte lane width

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_WAIT = 1'b1
    } rd_state_e;
endpackage

// File: rtl/nor_addr_map.sv
// Translates a request address into memory pins and a page tag.
// Word mode: the low ADDR_W bits are the word address; byte-select stays 0.
// Byte mode: bit 0 selects the byte, the bits above it form the word address.
// Assumes: purely combinational; the caller registers the results.
module nor_addr_map #(
    parameter int ADDR_W    = 22,
    parameter int PAGE_BITS = 3,
    localparam int TAG_W    = ADDR_W - PAGE_BITS
) (
    input  logic [ADDR_W:0]   req_addr,
    input  logic              byte_mode,
    output logic [ADDR_W-1:0] pin_addr,
    output logic              pin_bsel,
    output logic [TAG_W-1:0]  page_tag
);
    // Select the word address and byte-select by addressing mode.
    always_comb begin
        if (byte_mode) begin
            pin_addr = req_addr[ADDR_W:1];
            pin_bsel = req_addr[0];
        end else begin
            pin_addr = req_addr[ADDR_W-1:0];
            pin_bsel = 1'b0;
        end
        page_tag = pin_addr[ADDR_W-1:PAGE_BITS];
    end
endmodule

// File: rtl/nor_page_track.sv
// Holds the open page (tag and mode) and its validity, and runs the idle timer.
// The open flag doubles as the chip-enable state: a page is open exactly while
// chip-enable is asserted. Closes the page after IDLE_LIMIT idle cycles.
// Assumes: IDLE_LIMIT >= 1; open_en is high only on an accepting edge.
module nor_page_track #(
    parameter int TAG_W      = 19,
    parameter int IDLE_LIMIT = 16,
    localparam int IDLE_W    = $clog2(IDLE_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic             idle_tick,
    input  logic [TAG_W-1:0] cand_tag,
    input  logic             cand_mode,
    output logic             page_hit,
    output logic             page_open
);
    logic [TAG_W-1:0]  open_tag;
    logic              open_mode;
    logic [IDLE_W-1:0] idle_cnt;

    // Record the page opened by an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_tag  <= '0;
            open_mode <= 1'b0;
        end else if (open_en) begin
            open_tag  <= cand_tag;
            open_mode <= cand_mode;
        end
    end

    // Open on accept, close when the idle run reaches its limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_open <= 1'b0;
            idle_cnt  <= '0;
        end else if (open_en || !idle_tick) begin
            page_open <= page_open | open_en;
            idle_cnt  <= '0;
        end else if (page_open) begin
            if (idle_cnt == IDLE_W'(IDLE_LIMIT - 1)) begin
                page_open <= 1'b0;
                idle_cnt  <= '0;
            end else begin
                idle_cnt  <= idle_cnt + 1'b1;
            end
        end
    end

    // A hit needs an open page with matching tag and mode.
    always_comb begin
        page_hit = page_open && (open_tag == cand_tag) && (open_mode == cand_mode);
    end
endmodule

// File: rtl/nor_wait_timer.sv
// Down-counter for the access wait. On load it picks the full wait, or for a
// page hit the smaller of the page and full waits; zero is raised to one.
// done is high during the last cycle of the wait.
// Assumes: load is not raised while a wait is running.
module nor_wait_timer #(
    parameter int WAIT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              use_page,
    input  logic [WAIT_W-1:0] full_wait,
    input  logic [WAIT_W-1:0] page_wait,
    output logic              done
);
    logic [WAIT_W-1:0] cnt;
    logic [WAIT_W-1:0] pick;
    logic [WAIT_W-1:0] eff;

    // Choose the wait for the request being accepted.
    always_comb begin
        if (use_page && (page_wait < full_wait)) pick = page_wait;
        else                                     pick = full_wait;
        eff = (pick == '0) ? WAIT_W'(1) : pick;
    end

    // Load on accept, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= eff;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == WAIT_W'(1));
endmodule

// File: rtl/nor_page_reader.sv
// Top of the page-mode NOR read controller. Accepts one read at a time,
// drives the memory pins, waits the full or page wait, samples the data bus
// and returns it with a one-cycle strobe. Chip-enable and output-enable
// follow the open-page flag; write-enable is held inactive.
// Assumes: DATA_W >= 8; wait inputs and byte_mode are sampled on acceptance.
module nor_page_reader
    import nor_rd_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int DATA_W     = 16,
    parameter int WAIT_W     = 5,
    parameter int IDLE_LIMIT = 16,
    parameter int PAGE_BITS  = PAGE_BITS_DEF,
    localparam int TAG_W     = ADDR_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic [WAIT_W-1:0] full_wait,
    input  logic [WAIT_W-1:0] page_wait,
    input  logic              req_valid,
    input  logic [ADDR_W:0]   req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_bsel,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    input  logic [DATA_W-1:0] mem_dq
);
    rd_state_e         state;
    logic              accept;
    logic              idle_tick;
    logic              page_hit;
    logic              page_open;
    logic              wait_done;
    logic              mode_q;
    logic [ADDR_W-1:0] map_addr;
    logic              map_bsel;
    logic [TAG_W-1:0]  map_tag;

    assign req_ready = (state == RD_IDLE);
    assign accept    = req_valid && req_ready;
    assign idle_tick = req_ready && !req_valid;

    nor_addr_map #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_map (
        .req_addr (req_addr),
        .byte_mode(byte_mode),
        .pin_addr (map_addr),
        .pin_bsel (map_bsel),
        .page_tag (map_tag)
    );

    nor_page_track #(.TAG_W(TAG_W), .IDLE_LIMIT(IDLE_LIMIT)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (accept),
        .idle_tick(idle_tick),
        .cand_tag (map_tag),
        .cand_mode(byte_mode),
        .page_hit (page_hit),
        .page_open(page_open)
    );

    nor_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .use_page (page_hit),
        .full_wait(full_wait),
        .page_wait(page_wait),
        .done     (wait_done)
    );

    // Sequence between waiting for a request and waiting for data.
    always_ff @(posedge clk) begin
        if (!rst_n)                               state <= RD_IDLE;
        else if (state == RD_IDLE && accept)      state <= RD_WAIT;
        else if (state == RD_WAIT && wait_done)   state <= RD_IDLE;
    end

    // Latch the pin address and mode of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_bsel <= 1'b0;
            mode_q   <= 1'b0;
        end else if (accept) begin
            mem_addr <= map_addr;
            mem_bsel <= map_bsel;
            mode_q   <= byte_mode;
        end
    end

    // Sample the data bus at the end of the wait and strobe the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= (state == RD_WAIT) && wait_done;
            if ((state == RD_WAIT) && wait_done) begin
                if (mode_q) rsp_data <= {{(DATA_W - LANE_W){1'b0}}, mem_dq[LANE_W-1:0]};
                else        rsp_data <= mem_dq;
            end
        end
    end

    // Control pins: enables follow the open page, writes never happen.
    assign mem_ce_n = !page_open;
    assign mem_oe_n = !page_open;
    assign mem_we_n = 1'b1;
endmodule

// File: rtl/nor_page_reader_chk.sv
// Property checker for nor_page_reader, attached by bind below.
// Assumes: same parameter values as the checked instance.
module nor_page_reader_chk #(
    parameter int ADDR_W     = 22,
    parameter int IDLE_LIMIT = 16,
    localparam int RUN_W     = $clog2(IDLE_LIMIT + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_bsel,
    input logic              mem_ce_n,
    input logic              mem_oe_n
);
    logic [RUN_W-1:0] idle_run;

    // Count consecutive ready cycles without a request, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        idle_run <= '0;
        else if (!(req_ready && !req_valid))               idle_run <= '0;
        else if (idle_run != RUN_W'(IDLE_LIMIT))           idle_run <= idle_run + 1'b1;
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                  // R10
    AST_READY_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);                                   // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> ($stable(mem_addr) && $stable(mem_bsel)));   // R10
    AST_PINS_DURING_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (!mem_ce_n && !mem_oe_n));                   // R3
    AST_OE_FOLLOWS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> mem_oe_n);                                     // R5
    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_run == RUN_W'(IDLE_LIMIT)) |-> mem_ce_n);             // R6
endmodule

bind nor_page_reader nor_page_reader_chk #(
    .ADDR_W    (ADDR_W),
    .IDLE_LIMIT(IDLE_LIMIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_bsel (mem_bsel),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n)
);

// File: tb/nor_page_reader_test.sv
`timescale 1ns/1ps
module nor_page_reader_test;
    localparam int AW   = 22;
    localparam int DW   = 16;
    localparam int WW   = 5;
    localparam int IDLE = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          byte_mode;
    logic [WW-1:0] full_wait, page_wait;
    logic          req_valid;
    logic [AW:0]   req_addr;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] mem_addr;
    logic          mem_bsel, mem_ce_n, mem_oe_n, mem_we_n;
    logic [DW-1:0] mem_dq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    logic [15:0] qd[$];
    int          ql[$];
    int          qa[$];
    string       qr[$];
    bit          prev_rsp = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nor_page_reader uut (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .full_wait(full_wait), .page_wait(page_wait),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
        .mem_bsel(mem_bsel), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq(mem_dq)
    );

    function automatic logic [15:0] word_of(input logic [AW-1:0] a);
        return a[15:0] ^ {a[7:0], a[21:14]};
    endfunction

    // Memory model: distinct value per word and byte; garbage when disabled.
    logic [15:0] mw;
    assign mw     = word_of(mem_addr);
    assign mem_dq = (mem_ce_n || mem_oe_n) ? 16'hDEAD :
                    (byte_mode ? {8'hEE, (mem_bsel ? mw[15:8] : mw[7:0])} : mw);

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic set_waits(input int f, input int p);
        full_wait = WW'(f);
        page_wait = WW'(p);
    endtask

    // Driver: issue one read, push the expected item, hold a junk request
    // while busy, and check the pins each cycle until the response.
    task automatic rd(input logic [AW:0] a, input bit bm, input bit hit, input string rq);
        int w;
        logic [AW-1:0] ea;
        logic eb;
        logic [15:0] ed, ew;
        chk(req_ready == 1'b1, "R10", "ready before request", 32'(req_ready), 1);
        w = hit ? ((int'(page_wait) < int'(full_wait)) ? int'(page_wait) : int'(full_wait))
                : int'(full_wait);
        if (w == 0) w = 1;
        ea = bm ? a[AW:1] : a[AW-1:0];
        eb = bm ? a[0] : 1'b0;
        ew = word_of(ea);
        ed = bm ? {8'h00, (eb ? ew[15:8] : ew[7:0])} : ew;
        byte_mode = bm;
        req_addr  = a;
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        qd.push_back(ed);
        ql.push_back(w);
        qa.push_back(cyc);
        qr.push_back(rq);
        req_addr = a ^ 23'h2AAAAA;
        do begin
            @(negedge clk);
            if (!rsp_valid) begin
                chk(!mem_ce_n && !mem_oe_n, "R3", "enables during wait",
                    {30'd0, mem_ce_n, mem_oe_n}, 0);
                chk(mem_addr == ea, "R7", "address pins (R10 hold)", 32'(mem_addr), 32'(ea));
                chk(mem_bsel == eb, "R7", "byte select", 32'(mem_bsel), 32'(eb));
                chk(req_ready == 1'b0, "R10", "not ready while busy", 32'(req_ready), 0);
                chk(mem_we_n == 1'b1, "R2", "write enable high", 32'(mem_we_n), 1);
            end
        end while (!rsp_valid);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare each response against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            chk(!prev_rsp, "R10", "response strobe one cycle", 1, 0);
            if (qd.size() == 0) begin
                chk(1'b0, "R10", "unexpected response", 32'(rsp_data), 0);
            end else begin
                logic [15:0] d;
                int l, acc;
                string r;
                d = qd.pop_front();
                l = ql.pop_front();
                acc = qa.pop_front();
                r = qr.pop_front();
                chk(rsp_data == d, r, "read data", 32'(rsp_data), 32'(d));
                chk((cyc - acc) == l, r, "latency", 32'(cyc - acc), 32'(l));
            end
        end
        prev_rsp = rst_n && rsp_valid;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; byte_mode = 1'b0;
        set_waits(7, 3);
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "pins in reset",
            {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(rsp_valid == 1'b0, "R1", "no response in reset", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
        chk(mem_ce_n == 1'b1, "R1", "chip enable off after reset", 32'(mem_ce_n), 1);

        rd(23'h000100, 0, 0, "R1");      // first access: full wait
        rd(23'h000105, 0, 1, "R4");      // same page
        rd(23'h000107, 0, 1, "R4");
        rd(23'h000108, 0, 0, "R3");      // next page
        idle(IDLE - 1);
        chk(mem_ce_n == 1'b0, "R6", "still enabled below limit", 32'(mem_ce_n), 0);
        rd(23'h00010A, 0, 1, "R6");
        idle(IDLE);
        chk(mem_ce_n && mem_oe_n, "R6", "released at limit",
            {30'd0, mem_ce_n, mem_oe_n}, 3);
        rd(23'h00010A, 0, 0, "R5");      // same page, chip enable was released

        rd(23'h000180, 0, 0, "R3");
        rd(23'h000302, 1, 0, "R11");     // same page tag, other mode
        rd(23'h00030F, 1, 1, "R7");
        rd(23'h000310, 1, 0, "R7");
        rd(23'h000311, 1, 1, "R7");
        rd(23'h400189, 0, 0, "R7");      // top bit ignored in word mode
        rd(23'h00018A, 0, 1, "R4");

        set_waits(2, 5);
        rd(23'h000200, 0, 0, "R8");
        rd(23'h000201, 0, 1, "R8");      // page wait capped at full wait

        set_waits(0, 0);
        rd(23'h000240, 0, 0, "R9");
        rd(23'h000241, 0, 1, "R9");

        set_waits(20, 1);
        rd(23'h000400, 0, 0, "R3");
        rd(23'h000407, 0, 1, "R4");

        idle(3);
        chk(qd.size() == 0, "R10", "all responses received", 32'(qd.size()), 0);
        chk(mem_we_n == 1'b1, "R2", "write enable high at end", 32'(mem_we_n), 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule